// File: doc/BRIEF.md
# Write-Through Data Cache with Store Posting Buffer

This block is a direct-mapped, one-word-per-line data cache placed between a processor request port and a slower main-memory port. Reads that find their word in the cache are answered one cycle after acceptance. Reads that miss fetch the word from memory, install it in its line and return it. Stores are never allocated. A store that finds its word in the cache updates that word. Every store, hit or miss, is posted into a small first-in first-out buffer, and the buffer drains to memory in the background.

The processor request channel uses valid/ready. A request transfers on a cycle where both are high. Ready is low while a read miss is outstanding. Ready is also low for a store, but not for a read, while the posting buffer is full. The response channel carries only a valid strobe and has no back-pressure.

The memory read-request and write channels are valid/ready: valid, address and data hold steady until ready is seen. The memory read response is a one-cycle valid strobe with data and is always accepted. A read that misses the cache while the buffer still holds a store to the same word is answered from the youngest such store and is not sent to memory.

Top module: `wt_cache`

## Requirements
- R1: After reset, every line is invalid and the buffer is empty: cpu_req_ready is 1, while cpu_rsp_valid, mem_rd_valid and mem_wr_valid are 0, and the first read of any address goes to memory.
- R2: A read whose line is valid and whose stored tag equals the address tag raises cpu_rsp_valid with the cached word in the cycle after acceptance, and issues no memory read.
- R3: A read miss asserts mem_rd_valid with the word address, holding both until mem_rd_ready. The word returned with mem_rsp_valid appears on cpu_rsp_rdata, with cpu_rsp_valid, in the following cycle, and is written into the line so that the next read of that address hits.
- R4: The line index is the low log2(LINES) bits of the word address and the tag is the remaining high bits. Two addresses with equal index and different tags evict each other.
- R5: A store that hits updates the cached word in the cycle it is accepted, and a later read of that address returns the new word without a memory read.
- R6: A store that misses leaves every line unchanged: the word already held in its line still hits afterwards and returns its old value.
- R7: Every accepted store reaches memory exactly once, oldest first. mem_wr_valid is high whenever the buffer is not empty, and the address and data hold steady until mem_wr_ready.
- R8: The buffer holds WB_DEPTH stores. While it is full, cpu_req_ready is 0 for a store and stays 1 for a read.
- R9: A read that misses the cache while the buffer holds a store to the same word address returns the youngest such store's data in the cycle after acceptance, with no memory read.
- R10: Only one miss is in flight at a time: cpu_req_ready is 0 from the acceptance of a read miss until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept the request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid (one cycle) |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts read request |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rsp_valid | input | 1 | Memory read data valid (one cycle) |
| mem_rsp_data | input | DATA_W | Memory read data |
| mem_wr_valid | output | 1 | Buffered store ready for memory |
| mem_wr_ready | input | 1 | Memory accepts the store |
| mem_wr_addr | output | ADDR_W | Store word address |
| mem_wr_data | output | DATA_W | Store data |

## Verification
The bench builds the cache with an 8-bit word address, four lines and a four-entry buffer. With four lines, conflicting addresses such as 0x21 and 0x31 are easy to pick. With four entries, the full buffer is reached after four posted stores once the memory write channel is stalled. That stall also keeps duplicate stores to one word resident, which brings youngest-entry forwarding within reach. A stalled read-request channel exposes the hold rules and the single-miss rule.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0] line_vld;
  logic [TAG_W-1:0] line_tag  [LINES];
  logic [DATA_W-1:0] line_word [LINES];

  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;

  assign lk_idx  = lk_addr[IDX_W-1:0];
  assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
  assign upd_idx = upd_addr[IDX_W-1:0];
  assign upd_tag = upd_addr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)   line_vld[g] <= 1'b0;
      else if (sel) line_vld[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        line_tag[g]  <= upd_tag;
        line_word[g] <= upd_data;
      end
    end
  end

  assign lk_hit  = line_vld[lk_idx] && (line_tag[lk_idx] == lk_tag);
  assign lk_data = line_word[lk_idx];
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic              head_valid,
  input  logic              head_ready,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              fwd_hit,
  output logic [DATA_W-1:0] fwd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  slot_vld;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [DEPTH-1:0]  slot_match;
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic              pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = &slot_vld;
  assign head_valid = |slot_vld;
  assign pop        = head_valid && head_ready;
  assign head_addr  = slot_addr[rd_ptr];
  assign head_data  = slot_data[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                slot_vld[g] <= 1'b0;
      else if (push && wr_ptr == PTR_W'(g))      slot_vld[g] <= 1'b1;
      else if (pop && rd_ptr == PTR_W'(g))       slot_vld[g] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PTR_W'(g)) begin
        slot_addr[g] <= push_addr;
        slot_data[g] <= push_data;
      end
    end
    assign slot_match[g] = slot_vld[g] && (slot_addr[g] == look_addr);
  end

  // Walk from oldest to newest; the last match seen is the youngest store.
  always_comb begin
    logic [PTR_W-1:0] s;
    fwd_hit  = 1'b0;
    fwd_data = '0;
    s        = rd_ptr;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_match[s]) begin
        fwd_hit  = 1'b1;
        fwd_data = slot_data[s];
      end
      s = step(s);
    end
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  input  logic              fwd_hit,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic              wb_full,
  output logic              wb_push,
  output logic              upd_en,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [DATA_W-1:0] upd_data,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  wtc_state_e        state;
  logic [ADDR_W-1:0] miss_addr;
  logic              accept, rd_acc, wr_acc, refill, rd_quick;

  assign cpu_req_ready = (state == ST_IDLE) && !(cpu_req_write && wb_full);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign rd_acc        = accept && !cpu_req_write;
  assign wr_acc        = accept && cpu_req_write;
  assign refill        = (state == ST_MWAIT) && mem_rsp_valid;
  assign rd_quick      = rd_acc && (lk_hit || fwd_hit);

  assign wb_push  = wr_acc;
  assign upd_en   = refill || (wr_acc && lk_hit);
  assign upd_addr = refill ? miss_addr : cpu_req_addr;
  assign upd_data = refill ? mem_rsp_data : cpu_req_wdata;

  assign mem_rd_valid = (state == ST_MREQ);
  assign mem_rd_addr  = miss_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      miss_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (rd_acc && !lk_hit && !fwd_hit) begin
          state     <= ST_MREQ;
          miss_addr <= cpu_req_addr;
        end
        ST_MREQ:  if (mem_rd_ready)  state <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= rd_quick || refill;
      if (refill)        cpu_rsp_rdata <= mem_rsp_data;
      else if (rd_quick) cpu_rsp_rdata <= lk_hit ? lk_data : fwd_data;
    end
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LINES    = 16,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  logic              lk_hit, fwd_hit, wb_full, wb_push, upd_en;
  logic [DATA_W-1:0] lk_data, fwd_data, upd_data;
  logic [ADDR_W-1:0] upd_addr;

  wtc_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (cpu_req_addr),
    .lk_hit   (lk_hit),
    .lk_data  (lk_data),
    .upd_en   (upd_en),
    .upd_addr (upd_addr),
    .upd_data (upd_data)
  );

  wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wb_push),
    .push_addr  (cpu_req_addr),
    .push_data  (cpu_req_wdata),
    .full       (wb_full),
    .head_valid (mem_wr_valid),
    .head_ready (mem_wr_ready),
    .head_addr  (mem_wr_addr),
    .head_data  (mem_wr_data),
    .look_addr  (cpu_req_addr),
    .fwd_hit    (fwd_hit),
    .fwd_data   (fwd_data)
  );

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .lk_hit        (lk_hit),
    .lk_data       (lk_data),
    .fwd_hit       (fwd_hit),
    .fwd_data      (fwd_data),
    .wb_full       (wb_full),
    .wb_push       (wb_push),
    .upd_en        (upd_en),
    .upd_addr      (upd_addr),
    .upd_data      (upd_data),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_write,
  input logic              cpu_rsp_valid,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rsp_valid,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data
);
  localparam int CNT_W = $clog2(DEPTH + 2);

  logic [CNT_W-1:0] occ;
  logic             in_flight;
  logic             push_seen, pop_seen;

  assign push_seen = cpu_req_valid && cpu_req_ready && cpu_req_write;
  assign pop_seen  = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ       <= '0;
      in_flight <= 1'b0;
    end else begin
      occ <= occ + CNT_W'(push_seen) - CNT_W'(pop_seen);
      if (mem_rd_valid && mem_rd_ready) in_flight <= 1'b1;
      else if (mem_rsp_valid)           in_flight <= 1'b0;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_full_blocks_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !(cpu_req_ready && cpu_req_write));

  assert_drain_when_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) == mem_wr_valid);

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_fill_responds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && mem_rsp_valid) |=> cpu_rsp_valid);

  assert_single_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || in_flight) |-> !cpu_req_ready);
endmodule

bind wt_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_write (cpu_req_write),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready),
  .mem_wr_addr   (mem_wr_addr),
  .mem_wr_data   (mem_wr_data)
);

// File: tb/tb_wt_cache.sv
`timescale 1ns/1ps
module tb_wt_cache;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          mem_rd_valid, mem_rd_ready = 1'b1;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          mem_wr_valid, mem_wr_ready = 1'b1;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  always #10 clk = ~clk;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(4), .WB_DEPTH(4)) dut (.*);

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [256];
  logic [DW-1:0] sh  [256];
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];
  int            wcount = 0, rd_count = 0, cnt = 0;
  logic          pending = 1'b0;
  logic [AW-1:0] paddr = '0;

  function automatic logic [DW-1:0] initv(input int a);
    return 32'hC0DE_0000 | (32'(a) * 32'h101);
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pending) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[paddr];
        pending       <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (rst_n && mem_rd_valid && mem_rd_ready && !pending) begin
      pending  <= 1'b1;
      paddr    <= mem_rd_addr;
      cnt      <= LAT;
      rd_count <= rd_count + 1;
    end
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      mem[mem_wr_addr]     <= mem_wr_data;
      wlog_addr[wcount]    <= mem_wr_addr;
      wlog_data[wcount]    <= mem_wr_data;
      wcount               <= wcount + 1;
    end
  end

  // ---------------- checking ----------------
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk);
    sh[a] = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic missed);
    int rd0, lat;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
    while (!cpu_req_ready) @(negedge clk);
    rd0 = rd_count;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 0;
    while (!cpu_rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    d = cpu_rsp_rdata;
    missed = (rd_count != rd0);
  endtask

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp_miss;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h10, 32'h0,         1'b1},  // R1 cold miss, R3 fill
    '{1'b0, 8'h10, 32'h0,         1'b0},  // R2 hit
    '{1'b1, 8'h10, 32'h0000_1111, 1'b0},  // R5 store hit
    '{1'b0, 8'h10, 32'h0,         1'b0},  // R5 updated word
    '{1'b0, 8'h21, 32'h0,         1'b1},  // R4 index 1
    '{1'b0, 8'h31, 32'h0,         1'b1},  // R4 conflict evicts 0x21
    '{1'b0, 8'h21, 32'h0,         1'b1},  // R4 misses again
    '{1'b1, 8'h22, 32'h0000_2222, 1'b0},  // R6 store miss, empty line
    '{1'b0, 8'h13, 32'h0,         1'b1},  // index 3 fill
    '{1'b1, 8'h33, 32'h0000_3333, 1'b0},  // R6 store miss over 0x13
    '{1'b0, 8'h13, 32'h0,         1'b0},  // R6 line unchanged
    '{1'b0, 8'h22, 32'h0,         1'b1}   // R6 no allocation, R7 drained
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic          m;
    int            base;
    for (int i = 0; i < 256; i++) begin mem[i] = initv(i); sh[i] = initv(i); end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(cpu_req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(cpu_rsp_valid), 32'd0);
    chk("R1 mem_rd_valid", 32'(mem_rd_valid), 32'd0);
    chk("R1 mem_wr_valid", 32'(mem_wr_valid), 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
      else begin
        do_read(VEC[i].addr, d, m);
        chk($sformatf("R2/R3/R4/R5/R6 vec%0d data", i), d, sh[VEC[i].addr]);
        chk($sformatf("R2/R3/R4/R6 vec%0d miss", i), 32'(m), 32'(VEC[i].exp_miss));
      end
    end

    // R7 ordering of the three table stores
    chk("R7 store count", 32'(wcount), 32'd3);
    chk("R7 order 0", 32'(wlog_addr[0]), 32'h10);
    chk("R7 order 1", 32'(wlog_addr[1]), 32'h22);
    chk("R7 order 2", 32'(wlog_addr[2]), 32'h33);

    // R8 / R9 with the write channel stalled
    mem_wr_ready = 1'b0;
    base = wcount;
    do_write(8'h41, 32'hAAAA_0001);
    do_write(8'h42, 32'hAAAA_0002);
    do_write(8'h41, 32'hAAAA_0003);
    do_write(8'h43, 32'hAAAA_0004);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h44;
    #1 chk("R8 store blocked when full", 32'(cpu_req_ready), 32'd0);
    cpu_req_write = 1'b0; cpu_req_addr = 8'h10;
    #1 chk("R8 read open when full", 32'(cpu_req_ready), 32'd1);
    cpu_req_valid = 1'b0;
    do_read(8'h41, d, m);
    chk("R9 forward youngest data", d, 32'hAAAA_0003);
    chk("R9 no memory read", 32'(m), 32'd0);
    do_read(8'h10, d, m);
    chk("R8 read hit while full", d, 32'h0000_1111);
    mem_wr_ready = 1'b1;
    for (int k = 0; k < 50 && mem_wr_valid; k++) @(negedge clk);
    chk("R7 four drained", 32'(wcount - base), 32'd4);
    chk("R7 drain order a", 32'(wlog_addr[base+2]), 32'h41);
    chk("R7 drain order d", wlog_data[base+2], 32'hAAAA_0003);
    chk("R7 drain last", 32'(wlog_addr[base+3]), 32'h43);
    do_read(8'h41, d, m);
    chk("R9 after drain from memory", d, 32'hAAAA_0003);
    chk("R9 after drain is miss", 32'(m), 32'd1);

    // R3 / R10 stalled read-request channel
    mem_rd_ready = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h50;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 rd_valid held", 32'(mem_rd_valid), 32'd1);
    chk("R3 rd_addr held", 32'(mem_rd_addr), 32'h50);
    chk("R10 ready low in miss", 32'(cpu_req_ready), 32'd0);
    mem_rd_ready = 1'b1;
    for (int k = 0; k < 50 && !cpu_rsp_valid; k++) @(negedge clk);
    chk("R3 stalled miss data", cpu_rsp_rdata, sh[8'h50]);
    do_read(8'h50, d, m);
    chk("R3 filled line hits", 32'(m), 32'd0);

    // R1 reset mid-run clears valid bits
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset ready", 32'(cpu_req_ready), 32'd1);
    chk("R1 reset rsp", 32'(cpu_rsp_valid), 32'd0);
    rst_n = 1'b1;
    do_read(8'h50, d, m);
    chk("R1 line invalid after reset", 32'(m), 32'd1);
    chk("R1 data after reset", d, sh[8'h50]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule